// File: doc/BRIEF.md
# Sampling Delay Training Engine

This block searches for a good setting of the delay line that times the sampling of read data from a serial flash device. It is started by a single pulse. It then asks a transaction sequencer for a three-byte identification read with the delay line switched off, and keeps those bytes as the reference. After that it steps the delay setting upward from zero. At each setting it asks for another identification read and compares all three returned bytes with the reference.

The sweep tracks where matching reads begin and where they stop. From the passing region it picks one delay value and drives it onto the delay control word. It then reports the outcome in one of three ways: a pass, a fail, or a skip. A skip means that no device seems to be attached. On a fail the surrounding system is expected to lower the interface clock and run without the delay.

The sequencer runs one read at a time. It pulses a completion strobe when the three ID bytes are valid on its return bus. Changing clock rates, building the delay cells and sending the flash command are outside this block.

Top module: `dlytrain_top`

## Requirements
- R1: On an accepted start the delay control word drops to zero. The first read request is then flagged as the reference read, and the opcode output is 0x9F.
- R2: If the first two reference bytes are both 0xFF or both 0x00, training ends with pass 0, fail 0, cells 0 and a zero control word, and no sweep reads are issued. Byte 0 is `rd_id_i[7:0]` and byte 1 is `rd_id_i[15:8]`.
- R3: The sweep points are 0, STEP, 2·STEP and so on, for every multiple of STEP not above MAX_CELLS. MAX_CELLS itself is always added as the last point. Each point gets exactly one read, in increasing order.
- R4: The control word has bit 15 set, the cell count in the low bits and all other bits zero. A count of zero gives a word of all zeros. No count above MAX_CELLS is ever driven.
- R5: The first point whose read matches the reference becomes the left edge. After a match has been seen, the first mismatch ends the sweep, and the right edge becomes that point minus STEP. If no mismatch follows the first match, the right edge is MAX_CELLS.
- R6: A read matches only when all 24 ID bits are equal to the reference. A difference in any one byte counts as a mismatch.
- R7: Training passes only if a match was seen, right ≥ left, and right − left ≥ MIN_WINDOW (80 by default).
- R8: On a pass with left = 0 and right < MAX_CELLS, the chosen value is left + ⌊(right−left)·2/5⌋. On any other pass it is left + ⌊(right−left)/2⌋. The chosen value appears on `cells_o`, and the control word carries it.
- R9: On a fail, `fail_o` is 1, `cells_o` is 0 and the control word is zero.
- R10: At most one read is outstanding at a time. The next request waits for `rd_done_i`, and the control word does not change while a read is in flight.
- R11: `done_o` is high for exactly one cycle. The control word is final in that cycle, and `pass_o`, `fail_o` and `cells_o` hold until the next accepted start.
- R12: A start pulse that arrives while training is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| rd_req_o | output | 1 | One-cycle request for an ID read |
| rd_ref_o | output | 1 | High with the request that fetches the reference |
| rd_opcode_o | output | 8 | Opcode for the sequencer (0x9F) |
| rd_done_i | input | 1 | Read finished, `rd_id_i` valid |
| rd_id_i | input | 24 | Returned ID bytes, byte 0 in the low bits |
| dly_ctrl_o | output | 16 | Delay control word: bit 15 enable, low bits cell count |
| done_o | output | 1 | One-cycle end-of-training strobe |
| pass_o | output | 1 | Training found a valid window |
| fail_o | output | 1 | Training found no valid window |
| cells_o | output | CELL_W | Chosen cell count |

## Verification
A wrong sweep position shows up at the very next read request: the control word seen there stops following the expected point sequence, so the error is visible within one read. A wrong left or right edge, or a wrong end-of-sweep decision, shows up later, at the done strobe. It appears either as the wrong number of point reads or as a wrong chosen value, pass/fail flag or control word. Because the bench sweeps the passing region across the whole range, each edge and placement branch is reached near both ends of the range.

// File: rtl/dlytrain_pkg.sv
package dlytrain_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_REF_REQ, S_REF_WAIT, S_PT_SET, S_PT_REQ, S_PT_WAIT, S_FINISH
  } tr_state_e;

  localparam logic [15:0] DLY_EN_BIT = 16'h8000;

  // Device absent: first two bytes both all-ones or both all-zeros.
  function automatic logic id_is_blank(input logic [23:0] id);
    return ((id[7:0] == 8'hFF) && (id[15:8] == 8'hFF)) ||
           ((id[7:0] == 8'h00) && (id[15:8] == 8'h00));
  endfunction

  // Clamp a cell count and build the control word; zero disables the line.
  function automatic logic [15:0] dly_word(input logic [15:0] cells,
                                           input logic [15:0] max_c);
    logic [15:0] c;
    c = (cells > max_c) ? max_c : cells;
    return (c == 16'd0) ? 16'd0 : (DLY_EN_BIT | c);
  endfunction

  // Next sweep point: fixed stride, landing exactly on the top cell count.
  function automatic logic [15:0] next_point(input logic [15:0] p,
                                             input logic [15:0] stride,
                                             input logic [15:0] max_c);
    return ((p + stride) > max_c) ? max_c : (p + stride);
  endfunction

  // Placement inside the passing window.
  function automatic logic [15:0] place_cells(input logic [15:0] left,
                                              input logic [15:0] right,
                                              input logic [15:0] max_c);
    logic [15:0] span;
    span = right - left;
    if ((left == 16'd0) && (right < max_c))
      return left + ((span * 16'd2) / 16'd5);
    return left + (span / 16'd2);
  endfunction

endpackage

// File: rtl/dlytrain_window.sv
module dlytrain_window #(
  parameter int MAX_CELLS = 511,
  parameter int STEP      = 10,
  parameter int CELL_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              match_i,
  output logic [CELL_W-1:0] point_o,
  output logic [CELL_W-1:0] left_o,
  output logic [CELL_W-1:0] right_o,
  output logic              valid_o,
  output logic              sweep_end_o
);
  import dlytrain_pkg::*;

  localparam logic [15:0] MAXW  = 16'(MAX_CELLS);
  localparam logic [15:0] STEPW = 16'(STEP);

  logic [CELL_W-1:0] point_q, left_q, right_q;
  logic              valid_q;
  logic              at_top;
  logic              fall_edge;
  logic [15:0]       nxt;

  assign at_top      = (16'(point_q) == MAXW);
  assign fall_edge   = valid_q && !match_i;
  assign sweep_end_o = sample_i && (fall_edge || at_top);
  assign nxt         = next_point(16'(point_q), STEPW, MAXW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      point_q <= '0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else if (clear_i) begin
      point_q <= '0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else if (sample_i) begin
      if (fall_edge) begin
        right_q <= point_q - CELL_W'(STEP);
      end else begin
        if (!valid_q && match_i) left_q <= point_q;
        if (match_i) valid_q <= 1'b1;
        if (at_top) right_q <= point_q;
        else        point_q <= nxt[CELL_W-1:0];
      end
    end
  end

  assign point_o = point_q;
  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dlytrain_pick.sv
module dlytrain_pick #(
  parameter int MAX_CELLS  = 511,
  parameter int MIN_WINDOW = 80,
  parameter int CELL_W     = 9
) (
  input  logic [CELL_W-1:0] left_i,
  input  logic [CELL_W-1:0] right_i,
  input  logic              valid_i,
  output logic              ok_o,
  output logic [CELL_W-1:0] cells_o
);
  import dlytrain_pkg::*;

  localparam logic [15:0] MAXW = 16'(MAX_CELLS);
  localparam logic [15:0] MINW = 16'(MIN_WINDOW);

  logic [15:0] l16, r16, pick16;

  assign l16    = 16'(left_i);
  assign r16    = 16'(right_i);
  assign ok_o   = valid_i && (r16 >= l16) && ((r16 - l16) >= MINW);
  assign pick16 = place_cells(l16, r16, MAXW);
  assign cells_o = ok_o ? pick16[CELL_W-1:0] : '0;
endmodule

// File: rtl/dlytrain_seq.sv
module dlytrain_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rd_done_i,
  input  logic [23:0] rd_id_i,
  input  logic        sweep_end_i,
  output logic        clear_o,
  output logic        load_o,
  output logic        sample_o,
  output logic        match_o,
  output logic        finish_o,
  output logic        skip_o,
  output logic        rd_req_o,
  output logic        rd_ref_o,
  output logic        busy_o
);
  import dlytrain_pkg::*;

  tr_state_e   state_q;
  logic [23:0] ref_q;
  logic        skip_q;

  assign clear_o  = (state_q == S_IDLE) && start_i;
  assign load_o   = (state_q == S_PT_SET);
  assign sample_o = (state_q == S_PT_WAIT) && rd_done_i;
  assign match_o  = (rd_id_i == ref_q);
  assign finish_o = (state_q == S_FINISH);
  assign skip_o   = skip_q;
  assign rd_req_o = (state_q == S_REF_REQ) || (state_q == S_PT_REQ);
  assign rd_ref_o = (state_q == S_REF_REQ);
  assign busy_o   = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ref_q   <= '0;
      skip_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_REF_REQ;
          skip_q  <= 1'b0;
        end
        S_REF_REQ: state_q <= S_REF_WAIT;
        S_REF_WAIT: if (rd_done_i) begin
          ref_q <= rd_id_i;
          if (id_is_blank(rd_id_i)) begin
            skip_q  <= 1'b1;
            state_q <= S_FINISH;
          end else begin
            state_q <= S_PT_SET;
          end
        end
        S_PT_SET: state_q <= S_PT_REQ;
        S_PT_REQ: state_q <= S_PT_WAIT;
        S_PT_WAIT: if (rd_done_i) state_q <= sweep_end_i ? S_FINISH : S_PT_SET;
        S_FINISH: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlytrain_top.sv
module dlytrain_top #(
  parameter int          MAX_CELLS  = 511,
  parameter int          STEP       = 10,
  parameter int          MIN_WINDOW = 80,
  parameter logic [7:0]  ID_OPCODE  = 8'h9F,
  localparam int         CELL_W     = $clog2(MAX_CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rd_req_o,
  output logic              rd_ref_o,
  output logic [7:0]        rd_opcode_o,
  input  logic              rd_done_i,
  input  logic [23:0]       rd_id_i,
  output logic [15:0]       dly_ctrl_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [CELL_W-1:0] cells_o
);
  import dlytrain_pkg::*;

  localparam logic [15:0] MAXW = 16'(MAX_CELLS);

  // Internal events, visible to the bound checker.
  logic              clear_ev, load_ev, sample_ev, match_ev, finish_ev, skip_st, busy_st;
  logic              sweep_end;
  logic [CELL_W-1:0] point, left_edge, right_edge, pick_cells;
  logic              seen_match, pick_ok;

  logic [15:0]       dly_q;
  logic              done_q, pass_q, fail_q;
  logic [CELL_W-1:0] cells_q;

  dlytrain_seq u_seq (
    .clk, .rst_n, .start_i, .rd_done_i, .rd_id_i,
    .sweep_end_i (sweep_end),
    .clear_o     (clear_ev),
    .load_o      (load_ev),
    .sample_o    (sample_ev),
    .match_o     (match_ev),
    .finish_o    (finish_ev),
    .skip_o      (skip_st),
    .rd_req_o, .rd_ref_o,
    .busy_o      (busy_st)
  );

  dlytrain_window #(.MAX_CELLS(MAX_CELLS), .STEP(STEP), .CELL_W(CELL_W)) u_win (
    .clk, .rst_n,
    .clear_i     (clear_ev),
    .sample_i    (sample_ev),
    .match_i     (match_ev),
    .point_o     (point),
    .left_o      (left_edge),
    .right_o     (right_edge),
    .valid_o     (seen_match),
    .sweep_end_o (sweep_end)
  );

  dlytrain_pick #(.MAX_CELLS(MAX_CELLS), .MIN_WINDOW(MIN_WINDOW), .CELL_W(CELL_W)) u_pick (
    .left_i  (left_edge),
    .right_i (right_edge),
    .valid_i (seen_match),
    .ok_o    (pick_ok),
    .cells_o (pick_cells)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q   <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      cells_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (clear_ev) begin
        dly_q   <= '0;
        pass_q  <= 1'b0;
        fail_q  <= 1'b0;
        cells_q <= '0;
      end else if (load_ev) begin
        dly_q <= dly_word(16'(point), MAXW);
      end else if (finish_ev) begin
        done_q <= 1'b1;
        if (skip_st) begin
          dly_q <= '0;
        end else begin
          dly_q   <= dly_word(16'(pick_cells), MAXW);
          pass_q  <= pick_ok;
          fail_q  <= !pick_ok;
          cells_q <= pick_cells;
        end
      end
    end
  end

  assign rd_opcode_o = ID_OPCODE;
  assign dly_ctrl_o  = dly_q;
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;
  assign cells_o     = cells_q;
endmodule

// File: rtl/dlytrain_chk.sv
module dlytrain_chk #(
  parameter int MAX_CELLS = 511,
  parameter int CELL_W    = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_o,
  input logic              rd_ref_o,
  input logic              rd_done_i,
  input logic [15:0]       dly_ctrl_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic [CELL_W-1:0] cells_o,
  input logic              sample_ev,
  input logic              sweep_end,
  input logic [CELL_W-1:0] point
);
  localparam logic [15:0] LOW_MASK  = 16'((1 << CELL_W) - 1);
  localparam logic [15:0] KEEP_MASK = 16'h8000 | LOW_MASK;

  logic in_flight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_flight <= 1'b0;
    else if (rd_req_o)  in_flight <= 1'b1;
    else if (rd_done_i) in_flight <= 1'b0;
  end

  p_ref_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ref_o |-> (dly_ctrl_o == 16'd0));

  p_top_point_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ev && (32'(point) == MAX_CELLS)) |-> sweep_end);

  p_word_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_ctrl_o != 16'd0) |-> (dly_ctrl_o[15] && ((dly_ctrl_o & ~KEEP_MASK) == 16'd0) &&
                               (32'(dly_ctrl_o & LOW_MASK) <= MAX_CELLS) &&
                               ((dly_ctrl_o & LOW_MASK) != 16'd0)));

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

  p_fail_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fail_o) |-> ((dly_ctrl_o == 16'd0) && (cells_o == '0)));

  p_single_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !in_flight);

  p_word_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> $stable(dly_ctrl_o));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind dlytrain_top dlytrain_chk #(.MAX_CELLS(MAX_CELLS), .CELL_W(CELL_W)) u_chk (
  .clk, .rst_n, .rd_req_o, .rd_ref_o, .rd_done_i, .dly_ctrl_o, .done_o,
  .pass_o, .fail_o, .cells_o,
  .sample_ev (sample_ev),
  .sweep_end (sweep_end),
  .point     (point)
);

// File: tb/dlytrain_top_tb.sv
module dlytrain_top_tb;
  localparam int MAXC   = 255;
  localparam int STEP   = 10;
  localparam int MINWIN = 80;
  localparam int CW     = $clog2(MAXC + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          rd_req_o, rd_ref_o, rd_done_i = 1'b0;
  logic [7:0]    rd_opcode_o;
  logic [23:0]   rd_id_i = '0;
  logic [15:0]   dly_ctrl_o;
  logic          done_o, pass_o, fail_o;
  logic [CW-1:0] cells_o;

  always #10 clk = ~clk;

  dlytrain_top #(.MAX_CELLS(MAXC), .STEP(STEP), .MIN_WINDOW(MINWIN)) u_dut (
    .clk, .rst_n, .start_i, .rd_req_o, .rd_ref_o, .rd_opcode_o, .rd_done_i,
    .rd_id_i, .dly_ctrl_o, .done_o, .pass_o, .fail_o, .cells_o);

  int checks = 0, fails = 0;
  int g_lo, g_hi, g_bad;
  logic [23:0] g_ref;
  int n_ref, n_pts;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pt(input int k);
    return (k * STEP <= MAXC) ? k * STEP : MAXC;
  endfunction

  function automatic int word_of(input int c);
    return (c == 0) ? 0 : (32768 + c);
  endfunction

  // Sequencer model: one read at a time, two-cycle latency.
  initial begin
    logic [23:0] resp;
    int c;
    forever begin
      @(negedge clk);
      if (rd_req_o) begin
        if (rd_ref_o) begin
          n_ref++;
          chk(dly_ctrl_o == 16'd0, "R1 ref delay", int'(dly_ctrl_o), 0);
          chk(rd_opcode_o == 8'h9F, "R1 opcode", int'(rd_opcode_o), 159);
          resp = g_ref;
        end else begin
          // R3 / R4: point order and word format
          chk(int'(dly_ctrl_o) == word_of(pt(n_pts)), "R3 R4 sweep word",
              int'(dly_ctrl_o), word_of(pt(n_pts)));
          c = dly_ctrl_o[15] ? int'(dly_ctrl_o[14:0]) : 0;
          resp = (c >= g_lo && c <= g_hi) ? g_ref : (g_ref ^ (24'h1 << (8 * g_bad)));
          n_pts++;
        end
        repeat (2) @(negedge clk);
        rd_id_i = resp;
        rd_done_i = 1'b1;
        @(negedge clk);
        rd_done_i = 1'b0;
      end
    end
  end

  task automatic run_case(input int lo, input int hi, input int bad,
                          input logic [23:0] refid, input bit poke);
    int ntot, kf, kx, e_left, e_right, e_tested, e_cells, wait_n;
    bit e_valid, e_ok, blank;
    logic [CW-1:0] held_cells;
    g_lo = lo; g_hi = hi; g_bad = bad; g_ref = refid;
    n_ref = 0; n_pts = 0;
    blank = (refid[15:0] == 16'hFFFF) || (refid[15:0] == 16'h0000);
    ntot = MAXC / STEP + 1 + ((MAXC % STEP) != 0 ? 1 : 0);
    kf = -1; kx = -1;
    for (int k = 0; k < ntot; k++)
      if (kf < 0 && pt(k) >= lo && pt(k) <= hi) kf = k;
    if (kf >= 0)
      for (int k = kf + 1; k < ntot; k++)
        if (kx < 0 && pt(k) > hi) kx = k;
    e_valid = (kf >= 0);
    e_left  = e_valid ? pt(kf) : 0;
    e_right = (kx >= 0) ? pt(kx) - STEP : MAXC;
    e_tested = blank ? 0 : ((kx >= 0) ? kx + 1 : ntot);
    e_ok = !blank && e_valid && (e_right >= e_left) && (e_right - e_left >= MINWIN);
    if (!e_ok) e_cells = 0;
    else if (e_left == 0 && e_right < MAXC) e_cells = e_left + ((e_right - e_left) * 2) / 5;
    else e_cells = e_left + (e_right - e_left) / 2;

    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    wait_n = 0;
    while (!done_o && wait_n < 4000) begin @(negedge clk); wait_n++; end
    chk(done_o, "R11 done seen", int'(done_o), 1);
    chk(n_ref == 1, "R1 R12 one reference read", n_ref, 1);
    chk(n_pts == e_tested, "R2 R5 point reads", n_pts, e_tested);
    if (blank) begin
      chk(!pass_o && !fail_o, "R2 skip flags", int'({pass_o, fail_o}), 0);
      chk(dly_ctrl_o == 16'd0, "R2 skip word", int'(dly_ctrl_o), 0);
    end else begin
      chk(pass_o == e_ok, "R7 pass", int'(pass_o), int'(e_ok));
      chk(fail_o == !e_ok, "R9 fail", int'(fail_o), int'(!e_ok));
      chk(int'(cells_o) == e_cells, e_ok ? "R8 cells" : "R9 cells", int'(cells_o), e_cells);
      chk(int'(dly_ctrl_o) == word_of(e_cells), "R8 R9 final word",
          int'(dly_ctrl_o), word_of(e_cells));
    end
    held_cells = cells_o;
    @(negedge clk);
    chk(!done_o, "R11 done one cycle", int'(done_o), 0);
    chk(cells_o == held_cells, "R11 result held", int'(cells_o), int'(held_cells));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int widths[7];
    int n;
    widths = '{0, 30, 79, 85, 100, 150, 260};
    repeat (3) @(negedge clk);
    chk(!done_o && !rd_req_o && dly_ctrl_o == 16'd0 && !pass_o && !fail_o,
        "R11 reset state", int'(dly_ctrl_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: absent device, both blank forms
    run_case(0, 300, 0, 24'h12FFFF, 0);
    run_case(0, 300, 0, 24'h340000, 0);
    // R12: start pulse during a sweep
    run_case(100, 200, 1, 24'hC84017, 1);
    // R9: nothing passes
    run_case(300, 400, 2, 24'hC84017, 0);
    // R3 R5 R8: window reaching the top point, and right-after-clamp quirk
    run_case(160, 300, 0, 24'hEF4018, 0);
    run_case(160, 252, 1, 24'hEF4018, 0);
    // R6: mismatch in each single byte
    for (int b = 0; b < 3; b++) run_case(0, 120, b, 24'h9D6017, 0);
    // Near-exhaustive sweep of window placement and width
    n = 0;
    for (int lo = 0; lo <= MAXC; lo += 17) begin
      foreach (widths[i]) begin
        run_case(lo, lo + widths[i], n % 3, 24'hC22018 + 24'(n), 0);
        n++;
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule